// File: doc/BRIEF.md
# Serial Memory Slave Controller for a Two-Wire Bus

This block is the bus-facing control of a 4096-byte serial memory that acts as a slave on an I2C bus. It samples SCL and SDA from the bus and has one open-drain enable for SDA. It never drives SDA high: it either pulls the line low or releases it. Three strap inputs let eight of these devices share one bus. A write names a 12-bit word address and then fills a 64-byte page staging buffer. A read returns bytes from that address onward, one after another, until the master declines a byte.

When a write sequence with at least one data byte is closed by a STOP, the block starts a self-timed program cycle. The cycle lasts a set number of clocks. While it runs, the staged bytes are copied into the array and the device ignores its own address, so a master finds out that the write is complete by repeatedly addressing the device until it acknowledges. A supply-sense inhibit input stops any write from reaching the array.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the SDA enable is released (0), and the device acknowledges its address at the first attempt.
- R2: The device acknowledges an address byte only when its upper seven bits equal 1010 followed by strap_i[2:0]. Bit 0 of that byte selects read (1) or write (0). Any other address byte gets no acknowledge.
- R3: A write sequence is the address byte, an upper word-address byte of which only bits 3:0 are used, a lower word-address byte, and then data bytes. Every one of these bytes is acknowledged.
- R4: Data bytes step the address through bits 5:0 only, so data beyond offset 63 of a page wraps to offset 0 of the same page. Bytes outside that page are left unchanged.
- R5: A STOP after one or more data bytes starts a program cycle of WR_CYCLES clocks. During that cycle the device does not acknowledge its address and keeps SDA released. Afterwards the written bytes read back.
- R6: A STOP that comes before any data byte starts no program cycle. An address attempt made straight after it is acknowledged.
- R7: A repeated START followed by an address byte with bit 0 set returns data from the word address loaded by the write sequence before it.
- R8: A sequential read moves forward through the whole array and rolls over from address 4095 to address 0.
- R9: A write closed by a STOP while wr_inhibit_i is 1 leaves the array unchanged and starts no program cycle.
- R10: The SDA enable changes only while SCL is low.
- R11: A master NACK on a read byte ends the read. SDA stays released and the next address attempt is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| strap_i | input | 3 | Address strap inputs compared against address bits 3:1 |
| wr_inhibit_i | input | 1 | Supply-sense write inhibit, active high |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two functions can fall in the same cycle: decoding an incoming address byte and running a program cycle that is still copying the staged page into the array. The bench provokes this by addressing the device again at once after every STOP that closes a data write. It expects no acknowledge, then keeps polling until an acknowledge comes back, and then reads the bytes back and compares them with its own model of the array. The inhibit case is the mirror image: a STOP is issued while wr_inhibit_i is high, and the bench expects an immediate acknowledge and unchanged old data.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int AW        = 12,
  parameter int PW        = 6,
  parameter int WR_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wr_inhibit_i,
  output logic       sda_oe_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;
  localparam int CW    = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] WRC = CW'(WR_CYCLES);
  localparam logic [3:0] DEVTYPE = 4'b1010;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_RDAT} st_t;

  logic [1:0]       scl_s, sda_s;
  logic             scl_q, sda_q;
  st_t              st;
  logic [3:0]       bitcnt;
  logic [7:0]       sh, rbyte;
  logic [AW-1:0]    addr;
  logic [AW-PW-1:0] page;
  logic [PW-1:0]    wofs;
  logic [PAGE-1:0]  pval;
  logic [CW-1:0]    busy_cnt;
  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [PAGE];

  wire scl_n   = scl_s[1];
  wire sda_n   = sda_s[1];
  wire start_c = scl_q & scl_n & sda_q & ~sda_n;
  wire stop_c  = scl_q & scl_n & ~sda_q & sda_n;
  wire rise    = ~scl_q & scl_n;
  wire fall    = scl_q & ~scl_n;
  wire busy    = busy_cnt != '0;
  wire [CW-1:0] k = WRC - busy_cnt;
  wire commit  = busy && (k < CW'(PAGE)) && pval[k[PW-1:0]] && !wr_inhibit_i;
  wire take    = fall && bitcnt == 4'd8 && st == S_WDAT;
  wire match   = sh[7:1] == {DEVTYPE, strap_i} && !busy;
  wire [AW-1:0] addr_nx = addr + 1'b1;

  always_ff @(posedge clk) begin
    if (commit) mem[{page, k[PW-1:0]}] <= pbuf[k[PW-1:0]];
    if (take) pbuf[wofs] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      st <= S_IDLE; bitcnt <= '0; sh <= '0; rbyte <= '0; addr <= '0;
      page <= '0; wofs <= '0; pval <= '0; busy_cnt <= '0; sda_oe_o <= 1'b0;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_n;
      sda_q <= sda_n;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (busy_cnt == CW'(1)) pval <= '0;
      if (start_c) begin
        st <= busy ? S_IDLE : S_DEV;
        bitcnt <= '0;
        sda_oe_o <= 1'b0;
        if (!busy) pval <= '0;
      end else if (stop_c) begin
        if (st == S_WDAT) begin
          addr <= {page, wofs};
          if (|pval && !busy && !wr_inhibit_i) busy_cnt <= WRC;
        end
        st <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else if (rise && st != S_IDLE) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          case (st)
            S_DEV: begin
              st <= !sda_oe_o ? S_IDLE : (sh[0] ? S_RDAT : S_AHI);
              rbyte <= mem[addr];
            end
            S_AHI: st <= S_ALO;
            S_ALO: st <= S_WDAT;
            S_RDAT: begin
              if (sda_n) st <= S_IDLE;
              addr <= addr_nx;
              rbyte <= mem[addr_nx];
            end
            default: ;
          endcase
        end else begin
          sh <= {sh[6:0], sda_n};
          bitcnt <= bitcnt + 1'b1;
        end
      end else if (fall && st != S_IDLE) begin
        if (st == S_RDAT) begin
          sda_oe_o <= (bitcnt < 4'd8) ? ~rbyte[3'd7 - bitcnt[2:0]] : 1'b0;
        end else if (bitcnt == 4'd8) begin
          sda_oe_o <= 1'b1;
          case (st)
            S_DEV: if (!match) sda_oe_o <= 1'b0;
            S_AHI: addr[AW-1:8] <= sh[AW-9:0];
            S_ALO: begin
              addr[7:0] <= sh;
              page <= {addr[AW-1:8], sh[7:PW]};
              wofs <= sh[PW-1:0];
            end
            S_WDAT: begin
              pval[wofs] <= 1'b1;
              wofs <= wofs + 1'b1;
            end
            default: ;
          endcase
        end else begin
          sda_oe_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       busy,
  input logic       oe,
  input logic       inhibit,
  input logic [3:0] bitcnt
);
  p_silent_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !oe);

  p_inhibit_no_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(inhibit));

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> !scl_lvl);

  p_bit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
endmodule

bind i2c_eeprom_slave i2c_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_q), .busy(busy),
  .oe(sda_oe_o), .inhibit(wr_inhibit_i), .bitcnt(bitcnt)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int WRC = 300;
  localparam int Q   = 5;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, inh = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errs = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [4096];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];

  always #10 clk = ~clk;

  i2c_eeprom_slave #(.WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .wr_inhibit_i(inh), .sda_oe_o(sda_oe)
  );

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [11:0] pg_addr(input logic [11:0] a, input int i);
    return {a[11:6], 6'(a[5:0] + i)};
  endfunction

  function automatic logic [7:0] dev(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = !sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl = 1'b0;
    end
    sda_m = !mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic poll(input logic [7:0] d, output bit ack);
    bus_start(); send_byte(d, ack); bus_stop();
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, output bit allack);
    bit a0, a1, a2;
    bus_start(); send_byte(dev(strap, 1'b0), a0); send_byte(hi, a1); send_byte(lo, a2);
    allack = a0 & a1 & a2;
  endtask

  task automatic do_write(input logic [11:0] a, input int n, output bit allack);
    bit ak;
    set_addr({4'h0, a[11:8]}, a[7:0], allack);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak);
      allack &= ak;
      if (!inh) exp_mem[pg_addr(a, i)] = wbuf[i];
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [11:0] a, input int n);
    bit ak, ak2;
    set_addr({4'h0, a[11:8]}, a[7:0], ak);
    bus_start(); send_byte(dev(strap, 1'b1), ak2);
    chk(ak & ak2, "R7 read setup ack", int'(ak & ak2), 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic wait_ready(output int polls);
    bit ak = 1'b0;
    polls = 0;
    while (!ak && polls < 200) begin poll(dev(strap, 1'b0), ak); polls++; end
  endtask

  initial begin
    bit ak;
    int np;
    logic [11:0] a;
    int n, m;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset release", int'(sda_oe), 0);

    poll(dev(3'b010, 1'b0), ak);
    chk(!ak, "R2 strap mismatch nack", int'(ak), 0);
    poll({4'b1011, strap, 1'b0}, ak);
    chk(!ak, "R2 type code mismatch nack", int'(ak), 0);
    poll(dev(strap, 1'b0), ak);
    chk(ak, "R1 R2 first address ack", int'(ak), 1);

    set_addr(8'h01, 8'h23, ak); bus_stop();
    chk(ak, "R3 address bytes ack", int'(ak), 1);
    poll(dev(strap, 1'b0), ak);
    chk(ak, "R6 no-data stop leaves device free", int'(ak), 1);

    wbuf[0] = 8'hC7;
    set_addr(8'hF3, 8'hA5, ak);
    send_byte(wbuf[0], ak); bus_stop();
    chk(ak, "R3 data byte ack", int'(ak), 1);
    exp_mem[12'h3A5] = 8'hC7;
    poll(dev(strap, 1'b0), ak);
    chk(!ak, "R5 nack during program cycle", int'(ak), 0);
    wait_ready(np);
    chk(np >= 1 && np < 200, "R5 cycle ends", np, 1);
    do_read(12'h3A5, 1);
    chk(rbuf[0] == 8'hC7, "R3 R5 upper bits ignored readback", rbuf[0], 8'hC7);
    chk(sda_oe == 1'b0, "R11 released after nack", int'(sda_oe), 0);
    poll(dev(strap, 1'b0), ak);
    chk(ak, "R11 ack after read end", int'(ak), 1);

    wbuf[0] = 8'h5A;
    do_write(12'h080, 1, ak); wait_ready(np);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(12'h07E, 3, ak); wait_ready(np);
    do_read(12'h040, 1);
    chk(rbuf[0] == 8'h33, "R4 page wrap to offset 0", rbuf[0], 8'h33);
    do_read(12'h07E, 2);
    chk(rbuf[0] == 8'h11 && rbuf[1] == 8'h22, "R4 page tail", {rbuf[0], rbuf[1]}, 16'h1122);
    do_read(12'h080, 1);
    chk(rbuf[0] == 8'h5A, "R4 next page untouched", rbuf[0], 8'h5A);

    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    do_write(12'hFFE, 2, ak); wait_ready(np);
    wbuf[0] = 8'h0F;
    do_write(12'h000, 1, ak); wait_ready(np);
    do_read(12'hFFE, 3);
    chk(rbuf[0] == 8'hE1 && rbuf[1] == 8'hE2 && rbuf[2] == 8'h0F, "R8 rollover read",
        {rbuf[0], rbuf[1], rbuf[2]}, 24'hE1E20F);

    inh = 1'b1;
    wbuf[0] = 8'h99;
    do_write(12'h3A5, 1, ak);
    poll(dev(strap, 1'b0), ak);
    chk(ak, "R9 no cycle under inhibit", int'(ak), 1);
    inh = 1'b0;
    do_read(12'h3A5, 1);
    chk(rbuf[0] == 8'hC7, "R9 array unchanged", rbuf[0], 8'hC7);

    for (int it = 0; it < 8; it++) begin
      strap = 3'($urandom);
      a = 12'($urandom);
      n = 1 + int'($urandom % 24);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n, ak);
      chk(ak, "R3 random write acks", int'(ak), 1);
      poll(dev(strap, 1'b0), ak);
      chk(!ak, "R5 random busy nack", int'(ak), 0);
      wait_ready(np);
      m = (n < 64 - int'(a[5:0])) ? n : 64 - int'(a[5:0]);
      do_read(a, m);
      for (int i = 0; i < m; i++)
        chk(rbuf[i] == exp_mem[12'(a + i)], "R7 R8 random readback", rbuf[i], exp_mem[12'(a + i)]);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule